// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the transmit half of a chained-descriptor Ethernet DMA. Software builds a ring of four-word descriptors in memory. It hands each one over by setting the ownership bit, then pulses `start`. The block reads the current descriptor and fetches the byte count and buffer pointer. It pulls the buffer out of memory a word at a time into an internal byte FIFO. It then writes the status word back with ownership returned to software and follows the chain pointer to the next descriptor. The walk stops at the first descriptor software still owns, and the block goes idle until the next `start`.

Bytes leave on a valid/ready byte stream that carries a start-of-frame and an end-of-frame marker. A frame may be split over several descriptors. The block works in store-and-forward fashion: no byte of a frame leaves the FIFO until the descriptor closing that frame has been fully loaded. Checksum, padding and the MAC itself lie outside the block.

Top module: `txr_ring_dma`

## Requirements
- R1: After synchronous reset, `tx_valid`, `dma_busy`, `desc_err`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: A `start` pulse while idle begins a walk at the current descriptor. The descriptor layout in memory words is:
  - word 0: status, where bit 31 set means hardware owns it.
  - word 1: control, where bits [LEN_W-1:0] hold the byte count, bit 29 flags the first segment and bit 30 flags the last segment.
  - word 2: buffer byte address.
  - word 3: byte address of the next descriptor.
  The low two bits of both pointers are ignored.
- R3: Exactly the byte count of each buffer is sent, in rising address order, with the least significant byte of each memory word going first.
- R4: `tx_first` is high only on the first byte of a descriptor flagged first. `tx_last` is high only on the final byte of a descriptor flagged last.
- R5: A frame spread over several descriptors comes out as one unbroken byte sequence, in ring order.
- R6: No byte of a frame is presented on the stream before the descriptor carrying its last-segment flag has been completely loaded.
- R7: When a descriptor is finished, its status word is written back with bit 31 cleared and all other bits unchanged. The walk then moves to the next pointer, so the ring wraps through that pointer.
- R8: Reaching a descriptor whose bit 31 is clear makes the block go idle, with `dma_busy` low and no memory traffic. That descriptor stays current, and it is read again on the next `start`.
- R9: An owned descriptor with a byte count of zero sends nothing and has its flags ignored. It is handed back to software, and `desc_err` pulses for one cycle in the same cycle as that write-back.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_first` and `tx_last` hold their values.
- R11: `base_wr` while idle sets the current descriptor to the word address `base_addr`. `base_wr` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Kick: begin walking the ring from the current descriptor |
| base_wr | input | 1 | Load the current-descriptor pointer (idle only) |
| base_addr | input | ADDR_W | Word address of the descriptor to make current |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Word address for the read |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Memory write request (status write-back) |
| mem_wr_addr | output | ADDR_W | Word address for the write |
| mem_wr_data | output | 32 | Write data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Final byte of a frame |
| dma_busy | output | 1 | Ring walk in progress |
| desc_err | output | 1 | One-cycle pulse: zero-length descriptor closed |

## Verification
The assertions assume the following about the environment:
- The memory answers every read exactly one cycle after the request.
- Software does not change a descriptor while hardware owns it.
- No frame is longer than the FIFO, since a longer frame could never complete.

The bench's memory model answers in one cycle and only touches descriptors while `dma_busy` is low. Every frame it builds fits well inside the FIFO. Its sink drops `tx_ready` in several patterns, so that the stall-hold property is exercised rather than passing vacuously.

// File: rtl/txr_pkg.sv
package txr_pkg;

  // One entry of the byte FIFO: a data byte plus its frame markers.
  typedef struct packed {
    logic       first;
    logic       last;
    logic [7:0] data;
  } txr_byte_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_STAT_RQ,
    S_STAT_CP,
    S_CTRL_RQ,
    S_CTRL_CP,
    S_BUF_RQ,
    S_BUF_CP,
    S_NEXT_RQ,
    S_NEXT_CP,
    S_WORD_RQ,
    S_WORD_CP,
    S_PUSH,
    S_CLOSE
  } walk_state_t;

  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 29;
  localparam int LAST_BIT  = 30;

endpackage

// File: rtl/txr_walker.sv
// Descriptor walker: fetches descriptors and buffer words, pushes bytes,
// and writes back status with ownership returned.
module txr_walker
  import txr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              room4,
  output logic              push,
  output txr_byte_t         push_byte,
  output logic              busy,
  output logic              err
);

  localparam logic [ADDR_W-1:0] ONE_W = ADDR_W'(1);
  localparam logic [LEN_W-1:0]  ONE_L = LEN_W'(1);

  walk_state_t       st;
  logic [ADDR_W-1:0] cur_w, nxt_w, buf_w;
  logic [31:0]       stat_q, word_q;
  logic [LEN_W-1:0]  remain;
  logic              dfirst, dlast, zflag, sent_any;
  logic [1:0]        bidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cur_w    <= '0;
      nxt_w    <= '0;
      buf_w    <= '0;
      stat_q   <= '0;
      word_q   <= '0;
      remain   <= '0;
      dfirst   <= 1'b0;
      dlast    <= 1'b0;
      zflag    <= 1'b0;
      sent_any <= 1'b0;
      bidx     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (base_wr) cur_w <= base_addr;
          if (start)   st    <= S_STAT_RQ;
        end
        S_STAT_RQ: st <= S_STAT_CP;
        S_STAT_CP: begin
          stat_q <= mem_rdata;
          st     <= mem_rdata[OWN_BIT] ? S_CTRL_RQ : S_IDLE;
        end
        S_CTRL_RQ: st <= S_CTRL_CP;
        S_CTRL_CP: begin
          remain <= mem_rdata[LEN_W-1:0];
          dfirst <= mem_rdata[FIRST_BIT];
          dlast  <= mem_rdata[LAST_BIT];
          st     <= S_BUF_RQ;
        end
        S_BUF_RQ: st <= S_BUF_CP;
        S_BUF_CP: begin
          buf_w <= mem_rdata[ADDR_W+1:2];
          st    <= S_NEXT_RQ;
        end
        S_NEXT_RQ: st <= S_NEXT_CP;
        S_NEXT_CP: begin
          nxt_w    <= mem_rdata[ADDR_W+1:2];
          sent_any <= 1'b0;
          if (remain == '0) begin
            zflag <= 1'b1;
            st    <= S_CLOSE;
          end else begin
            zflag <= 1'b0;
            st    <= S_WORD_RQ;
          end
        end
        S_WORD_RQ: if (room4) st <= S_WORD_CP;
        S_WORD_CP: begin
          word_q <= mem_rdata;
          bidx   <= '0;
          st     <= S_PUSH;
        end
        S_PUSH: begin
          sent_any <= 1'b1;
          remain   <= remain - ONE_L;
          bidx     <= bidx + 2'd1;
          if (remain == ONE_L) begin
            st <= S_CLOSE;
          end else if (bidx == 2'd3) begin
            buf_w <= buf_w + ONE_W;
            st    <= S_WORD_RQ;
          end
        end
        S_CLOSE: begin
          cur_w <= nxt_w;
          st    <= S_STAT_RQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd_en = 1'b0;
    mem_addr  = '0;
    case (st)
      S_STAT_RQ: begin mem_rd_en = 1'b1;  mem_addr = cur_w;                end
      S_CTRL_RQ: begin mem_rd_en = 1'b1;  mem_addr = cur_w + ONE_W;        end
      S_BUF_RQ:  begin mem_rd_en = 1'b1;  mem_addr = cur_w + ADDR_W'(2);   end
      S_NEXT_RQ: begin mem_rd_en = 1'b1;  mem_addr = cur_w + ADDR_W'(3);   end
      S_WORD_RQ: begin mem_rd_en = room4; mem_addr = buf_w;                end
      default:   begin mem_rd_en = 1'b0;  mem_addr = '0;                   end
    endcase
  end

  assign mem_wr_en       = (st == S_CLOSE);
  assign mem_wr_addr     = cur_w;
  assign mem_wr_data     = stat_q & ~(32'd1 << OWN_BIT);
  assign err             = (st == S_CLOSE) && zflag;
  assign busy            = (st != S_IDLE);
  assign push            = (st == S_PUSH);
  assign push_byte.data  = word_q[{bidx, 3'b000} +: 8];
  assign push_byte.first = dfirst && !sent_any;
  assign push_byte.last  = dlast && (remain == ONE_L);

endmodule

// File: rtl/txr_byte_fifo.sv
// Byte FIFO with frame counting; the storage has a synchronous read so it
// maps onto block RAM.  DEPTH must be a power of two.
module txr_byte_fifo
  import txr_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  txr_byte_t wr_byte,
  input  logic      rd_en,
  output txr_byte_t rd_byte,
  output logic      rd_vld,
  output logic      room4,
  output logic      has_frame
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  txr_byte_t      ram [DEPTH];
  logic [PW-1:0]  wptr, rptr;
  logic [CW-1:0]  cnt, frames;
  logic           f_inc, f_dec;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wptr] <= wr_byte;
    if (rd_en) rd_byte   <= ram[rptr];
  end

  assign f_inc = wr_en && wr_byte.last;
  assign f_dec = rd_vld && rd_byte.last;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      frames <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (wr_en) wptr <= wptr + PW'(1);
      if (rd_en) rptr <= rptr + PW'(1);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + ONE_C;
        2'b01:   cnt <= cnt - ONE_C;
        default: cnt <= cnt;
      endcase
      case ({f_inc, f_dec})
        2'b10:   frames <= frames + ONE_C;
        2'b01:   frames <= frames - ONE_C;
        default: frames <= frames;
      endcase
    end
  end

  assign room4     = (DEPTH_C - cnt) >= CW'(4);
  assign has_frame = (frames != '0);

endmodule

// File: rtl/txr_stream_out.sv
// Registered stream stage: pops the FIFO only while a whole frame is held.
module txr_stream_out
  import txr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      has_frame,
  input  txr_byte_t rd_byte,
  input  logic      rd_vld,
  output logic      fifo_rd_en,
  output logic      tx_valid,
  input  logic      tx_ready,
  output logic [7:0] tx_data,
  output logic      tx_first,
  output logic      tx_last
);

  assign fifo_rd_en = has_frame && !rd_vld && (!tx_valid || tx_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_first <= 1'b0;
      tx_last  <= 1'b0;
    end else if (rd_vld) begin
      tx_valid <= 1'b1;
      tx_data  <= rd_byte.data;
      tx_first <= rd_byte.first;
      tx_last  <= rd_byte.last;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/txr_ring_dma.sv
module txr_ring_dma
  import txr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 14,
  parameter int FIFO_DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_first,
  output logic              tx_last,
  output logic              dma_busy,
  output logic              desc_err
);

  txr_byte_t push_byte, rd_byte;
  logic      push, room4, rd_en, rd_vld, has_frame;

  txr_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .start(start), .base_wr(base_wr),
    .base_addr(base_addr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .room4(room4), .push(push),
    .push_byte(push_byte), .busy(dma_busy), .err(desc_err)
  );

  txr_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_byte(push_byte),
    .rd_en(rd_en), .rd_byte(rd_byte), .rd_vld(rd_vld),
    .room4(room4), .has_frame(has_frame)
  );

  txr_stream_out u_out (
    .clk(clk), .rst(rst), .has_frame(has_frame), .rd_byte(rd_byte),
    .rd_vld(rd_vld), .fifo_rd_en(rd_en), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_first(tx_first),
    .tx_last(tx_last)
  );

endmodule

// File: rtl/txr_ring_dma_chk.sv
module txr_ring_dma_chk (
  input logic        clk,
  input logic        rst,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_first,
  input logic        tx_last,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic [31:0] mem_wr_data,
  input logic        dma_busy,
  input logic        desc_err
);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                 $stable(tx_first) && $stable(tx_last)));

  a_r7_owner_returned: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !mem_wr_data[31]);

  a_r7_one_access: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_en, mem_wr_en}));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !dma_busy |-> (!mem_rd_en && !mem_wr_en));

  a_r9_err_with_close: assert property (@(posedge clk) disable iff (rst)
    desc_err |-> mem_wr_en);

endmodule

bind txr_ring_dma txr_ring_dma_chk u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
  .dma_busy(dma_busy), .desc_err(desc_err)
);

// File: tb/tb_txr_ring_dma.sv
module tb_txr_ring_dma;

  localparam int AW    = 8;
  localparam int LIMIT = 150000;

  // {ready mode[31:28], segments[27:24], len0[23:16], len1[15:8], len2[7:0]}
  localparam logic [31:0] VEC [8] = '{
    32'h01010000, 32'h11040000, 32'h01070000, 32'h22050300,
    32'h1340010A, 32'h01400000, 32'h12023F00, 32'h2309100B
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, base_wr = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr, mem_wr_addr;
  logic [31:0]   mem_rdata = '0, mem_wr_data;
  logic          tx_valid, tx_first, tx_last, dma_busy, desc_err;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_data;

  logic [31:0] mem [256];
  logic [7:0]  rx_d [512];
  logic        rx_f [512];
  logic        rx_l [512];
  logic [7:0]  ex_d [512];
  int rx_n = 0, ex_n = 0, err_cnt = 0, mode = 0, cyc = 0;
  int errors = 0, checks = 0, ring_i = 0;

  txr_ring_dma #(.ADDR_W(AW), .LEN_W(14), .FIFO_DEPTH(256)) dut (
    .clk(clk), .rst(rst), .start(start), .base_wr(base_wr),
    .base_addr(base_addr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
    .dma_busy(dma_busy), .desc_err(desc_err)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == LIMIT) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Sink: set ready for the coming edge, then record a transfer.
  always @(negedge clk) begin
    case (mode)
      0:       tx_ready = 1'b1;
      1:       tx_ready = cyc[0];
      default: tx_ready = (cyc % 3 == 0);
    endcase
    if (tx_valid && tx_ready && rx_n < 512) begin
      rx_d[rx_n] = tx_data; rx_f[rx_n] = tx_first; rx_l[rx_n] = tx_last;
      rx_n++;
    end
    if (desc_err) err_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_rx();
    rx_n = 0; ex_n = 0; err_cnt = 0;
  endtask

  // Descriptor slot s lives at word 4*s, its buffer at word 64+16*s.
  // Pointers carry nonzero low bits, which the block must ignore (R2).
  task automatic put_desc(input int slot, input bit own, input int len,
                          input bit first, input bit last, input int seed,
                          input bit expect_it);
    int b = 4 * slot;
    int bw = 64 + 16 * slot;
    mem[b]   = {own, 19'd0, 12'hA5A};
    mem[b+1] = (32'(last) << 30) | (32'(first) << 29) | 32'(len);
    mem[b+2] = (32'(bw) << 2) | 32'd1;
    mem[b+3] = (32'(4 * ((slot + 1) % 4)) << 2) | 32'd3;
    for (int k = 0; k < len; k++) begin
      logic [7:0] v = 8'(seed + 7 * k);
      mem[bw + k / 4][8 * (k % 4) +: 8] = v;
      if (expect_it) begin ex_d[ex_n] = v; ex_n++; end
    end
  endtask

  task automatic kick();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    repeat (3) tick();
    while ((dma_busy || rx_n < ex_n || tx_valid) && g < 6000) begin
      tick(); g++;
    end
    check(g < 6000, "R2 completion", g, 0);
  endtask

  task automatic check_frame(input string req);
    int bad = 0, badm = 0;
    check(rx_n == ex_n, {req, " byte count"}, rx_n, ex_n);
    for (int i = 0; i < ex_n && i < rx_n; i++) begin
      if (rx_d[i] != ex_d[i]) bad++;
      if (rx_f[i] != (i == 0) || rx_l[i] != (i == ex_n - 1)) badm++;
    end
    check(bad == 0, {req, " R3 data"}, bad, 0);
    check(badm == 0, "R4 markers", badm, 0);
  endtask

  task automatic run_vec(input int v);
    logic [31:0] e = VEC[v];
    int n = int'(e[27:24]);
    int bad = 0;
    int lens [3];
    lens[0] = int'(e[23:16]); lens[1] = int'(e[15:8]); lens[2] = int'(e[7:0]);
    clear_rx();
    mode = int'(e[31:28]);
    for (int s = 0; s < n; s++)
      put_desc((ring_i + s) % 4, 1'b1, lens[s], s == 0, s == n - 1,
               v * 40 + s * 13 + 1, 1'b1);
    mem[4 * ((ring_i + n) % 4)][31] = 1'b0;
    kick();
    wait_done();
    check_frame("R5 vector");
    for (int s = 0; s < n; s++)
      if (mem[4 * ((ring_i + s) % 4)] != 32'h00000A5A) bad++;
    check(bad == 0, "R7 status write-back", bad, 0);
    check(!dma_busy, "R8 idle at software-owned", dma_busy, 0);
    ring_i = (ring_i + n) % 4;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check(!tx_valid && !dma_busy && !desc_err, "R1 reset outputs",
          {tx_valid, dma_busy, desc_err}, 0);
    check(!mem_rd_en && !mem_wr_en, "R1 no memory traffic",
          {mem_rd_en, mem_wr_en}, 0);

    // R11: load base while idle, slot 0
    base_addr = 8'd0; base_wr = 1'b1; tick(); base_wr = 1'b0;

    for (int v = 0; v < 8; v++) run_vec(v);

    // R6/R8: first half of a frame loaded, second half still owned by software
    clear_rx(); mode = 0;
    put_desc(ring_i, 1'b1, 20, 1'b1, 1'b0, 91, 1'b1);
    put_desc((ring_i + 1) % 4, 1'b0, 5, 1'b0, 1'b1, 150, 1'b1);
    kick();
    repeat (300) tick();
    check(rx_n == 0, "R6 held until frame complete", rx_n, 0);
    check(!dma_busy, "R8 stops at software-owned", dma_busy, 0);
    check(mem[4 * ring_i] == 32'h00000A5A, "R7 first half returned",
          mem[4 * ring_i], 32'h00000A5A);
    // R2/R8: restart picks up the same descriptor once it is owned
    mem[4 * ((ring_i + 1) % 4)][31] = 1'b1;
    mem[4 * ((ring_i + 2) % 4)][31] = 1'b0;
    kick();
    wait_done();
    check_frame("R5 split frame");
    ring_i = (ring_i + 2) % 4;

    // R9: zero-length descriptor
    clear_rx(); mode = 1;
    put_desc(ring_i, 1'b1, 0, 1'b1, 1'b1, 3, 1'b0);
    put_desc((ring_i + 1) % 4, 1'b1, 3, 1'b1, 1'b1, 200, 1'b1);
    mem[4 * ((ring_i + 2) % 4)][31] = 1'b0;
    kick();
    wait_done();
    check(err_cnt == 1, "R9 error pulse", err_cnt, 1);
    check(mem[4 * ring_i] == 32'h00000A5A, "R9 zero-length returned",
          mem[4 * ring_i], 32'h00000A5A);
    check_frame("R9 following frame");
    ring_i = (ring_i + 2) % 4;

    // R11: base write while busy is ignored
    clear_rx(); mode = 2;
    put_desc(ring_i, 1'b1, 60, 1'b1, 1'b1, 17, 1'b1);
    mem[4 * ((ring_i + 1) % 4)][31] = 1'b0;
    mem[4 * ((ring_i + 2) % 4)][31] = 1'b0;
    kick();
    repeat (20) tick();
    check(dma_busy, "R11 busy during long frame", dma_busy, 1);
    base_addr = AW'(4 * ((ring_i + 2) % 4)); base_wr = 1'b1; tick(); base_wr = 1'b0;
    wait_done();
    check_frame("R11 busy frame");
    clear_rx(); mode = 0;
    put_desc((ring_i + 1) % 4, 1'b1, 2, 1'b1, 1'b1, 77, 1'b1);
    kick();
    wait_done();
    check(rx_n == 2, "R11 base write while busy ignored", rx_n, 2);
    ring_i = (ring_i + 2) % 4;

    // R11: base write while idle redirects the walk
    clear_rx(); mode = 0;
    put_desc(ring_i, 1'b1, 6, 1'b1, 1'b1, 55, 1'b0);
    put_desc((ring_i + 2) % 4, 1'b1, 4, 1'b1, 1'b1, 120, 1'b1);
    mem[4 * ((ring_i + 3) % 4)][31] = 1'b0;
    base_addr = AW'(4 * ((ring_i + 2) % 4)); base_wr = 1'b1; tick(); base_wr = 1'b0;
    kick();
    wait_done();
    check_frame("R11 idle base load");
    check(mem[4 * ring_i][31] == 1'b1, "R11 skipped slot untouched",
          mem[4 * ring_i][31], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule